// File: doc/BRIEF.md
# Real-Time Clock with Calendar and Stopwatch

This block keeps wall-clock time from a 32.768 kHz oscillator. A binary prescaler of `STAGES` flip-flops (15 by default) turns the oscillator clock into one update per second. On each update it advances the time of day (hours, minutes, seconds) and a calendar made of day of week, date, month and year. It also raises an alarm at a chosen time of day, and it runs a minute-resolution countdown stopwatch. Five event flags record these events: each second, each minute, the midnight rollover, the alarm and the stopwatch expiry. Each flag has its own enable, and the flags combine into one interrupt line.

Software sets the clock by driving the load fields and pulsing `load` for one cycle. The load also restarts the prescaler, so the first second after a load has its full length. The stopwatch is armed the same way through `sw_load`. The flags stay set until software clears them. Writing a 1 to a bit of `irq_clr` for one cycle clears that flag. The control and status pins are plain levels and strobes. No data stream passes through the block, so no port uses a handshake.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds advance exactly 2^STAGES clock cycles after the cycle in which `load` was sampled, and then once every 2^STAGES cycles.
- R2: Seconds count 0..59 and minutes count 0..59; each wraps to 0 and carries into the next field. Hours count 0..23 and wrap to 0.
- R3: At midnight the day of week steps 0..6 and wraps to 0. The date advances and returns to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by four and 28 otherwise. All other months have 31 days.
- R4: After 31 December the month becomes 1 (January) and the year increments by one. Months are numbered 1..12.
- R5: A `load` pulse writes all time and date fields and clears the prescaler. A load in the same cycle as a due second update takes priority, and the update does not happen. Loaded values must be legal for their field.
- R6: In `irq_flags`, bit 0 sets on every second update and bit 1 sets when the seconds wrap from 59. Bit 2 sets when the hours wrap from 23 to 0 (midnight).
- R7: While `alarm_en` is high, bit 3 sets on the second update that makes hours, minutes and seconds equal the alarm setting. A load that writes a matching time does not set it.
- R8: `sw_load` writes the stopwatch count, which then decrements on each minute wrap. When it steps from 1 to 0, bit 4 sets and the count stays at 0. A `sw_load` in the same cycle as a minute wrap takes priority, and a count loaded as 0 raises no flag.
- R9: A set flag stays set until a cycle with the matching `irq_clr` bit high. If a flag's event and its clear fall in the same cycle, the flag ends up set.
- R10: An event whose `irq_en` bit is low does not set its flag. `irq` is high exactly when any flag is set.
- R11: After reset the time is 00:00:00, the day of week is 0, the date is 1, the month is 1 and the year is 0. The stopwatch count and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe that writes the load fields |
| load_hour | input | 5 | Hour to load, 0..23 |
| load_min | input | 6 | Minute to load, 0..59 |
| load_sec | input | 6 | Second to load, 0..59 |
| load_dow | input | 3 | Day of week to load, 0..6 |
| load_date | input | 5 | Day of month to load, 1..31 |
| load_month | input | 4 | Month to load, 1..12 |
| load_year | input | YEAR_W | Year to load |
| alarm_en | input | 1 | Enables alarm matching |
| alarm_hour | input | 5 | Alarm hour |
| alarm_min | input | 6 | Alarm minute |
| alarm_sec | input | 6 | Alarm second |
| sw_load | input | 1 | One-cycle strobe that writes the stopwatch count |
| sw_value | input | SW_W | Stopwatch start value in minutes |
| irq_en | input | 5 | Per-flag enable: 0 second, 1 minute, 2 midnight, 3 alarm, 4 stopwatch |
| irq_clr | input | 5 | Per-flag clear, same bit order |
| hour | output | 5 | Current hour |
| min | output | 6 | Current minute |
| sec | output | 6 | Current second |
| dow | output | 3 | Current day of week |
| date | output | 5 | Current day of month |
| month | output | 4 | Current month |
| year | output | YEAR_W | Current year |
| sw_left | output | SW_W | Remaining stopwatch minutes |
| irq_flags | output | 5 | Sticky event flags |
| irq | output | 1 | OR of all flags |

## Verification
Several events can land on the same second update. The most demanding case is the update out of 23:59:59 on 28 February of a non-leap year with the alarm set to 00:00:00. That one edge must raise the second, minute, midnight and alarm flags together and move the date to 1 March. Collisions between a strobe and an update are forced by asserting the strobe in the exact cycle of the due update. A clear against a flag's event must leave the flag set. A time load against the update must leave the loaded second in place. A stopwatch load against a minute wrap must leave the loaded count without a decrement.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FLAG_N      = 5;
  localparam int FLAG_SEC    = 0;
  localparam int FLAG_MIN    = 1;
  localparam int FLAG_MIDNT  = 2;
  localparam int FLAG_ALARM  = 3;
  localparam int FLAG_SW     = 4;

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                    return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int STAGES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  logic [STAGES-1:0] div_q;

  assign tick = (&div_q) & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> div_q == '0);
  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rtc_tod.sv
module rtc_tod (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [4:0] ld_hour,
  input  logic [5:0] ld_min,
  input  logic [5:0] ld_sec,
  output logic [4:0] hour_q,
  output logic [5:0] min_q,
  output logic [5:0] sec_q,
  output logic [4:0] nxt_hour,
  output logic [5:0] nxt_min,
  output logic [5:0] nxt_sec,
  output logic       min_roll,
  output logic       day_roll
);
  logic sec_top, min_top, hour_top;

  always_comb begin
    sec_top  = (sec_q == 6'd59);
    min_top  = (min_q == 6'd59);
    hour_top = (hour_q == 5'd23);
    nxt_sec  = sec_top ? 6'd0 : sec_q + 6'd1;
    nxt_min  = min_q;
    nxt_hour = hour_q;
    if (sec_top) begin
      nxt_min = min_top ? 6'd0 : min_q + 6'd1;
      if (min_top) nxt_hour = hour_top ? 5'd0 : hour_q + 5'd1;
    end
  end

  assign min_roll = tick & sec_top;
  assign day_roll = min_roll & min_top & hour_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hour_q <= '0; min_q <= '0; sec_q <= '0;
    end else if (load) begin
      hour_q <= ld_hour; min_q <= ld_min; sec_q <= ld_sec;
    end else if (tick) begin
      hour_q <= nxt_hour; min_q <= nxt_min; sec_q <= nxt_sec;
    end
  end

  p_fields_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q < 6'd60 && min_q < 6'd60 && hour_q < 5'd24);
  p_second_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && sec_q != 6'd59 |=> sec_q == $past(sec_q) + 6'd1);
endmodule

// File: rtl/rtc_date.sv
module rtc_date
  import rtc_pkg::*;
#(
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_roll,
  input  logic              load,
  input  logic [2:0]        ld_dow,
  input  logic [4:0]        ld_date,
  input  logic [3:0]        ld_month,
  input  logic [YEAR_W-1:0] ld_year,
  output logic [2:0]        dow_q,
  output logic [4:0]        date_q,
  output logic [3:0]        month_q,
  output logic [YEAR_W-1:0] year_q
);
  localparam logic [YEAR_W-1:0] YEAR_ONE = {{(YEAR_W-1){1'b0}}, 1'b1};

  logic leap, last_day;
  assign leap     = (year_q[1:0] == 2'b00);
  assign last_day = (date_q == month_days(month_q, leap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q <= '0; date_q <= 5'd1; month_q <= 4'd1; year_q <= '0;
    end else if (load) begin
      dow_q <= ld_dow; date_q <= ld_date; month_q <= ld_month; year_q <= ld_year;
    end else if (day_roll) begin
      dow_q <= (dow_q == 3'd6) ? 3'd0 : dow_q + 3'd1;
      if (!last_day) date_q <= date_q + 5'd1;
      else begin
        date_q <= 5'd1;
        if (month_q == 4'd12) begin
          month_q <= 4'd1;
          year_q  <= year_q + YEAR_ONE;
        end else month_q <= month_q + 4'd1;
      end
    end
  end

  p_date_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    date_q >= 5'd1 && date_q <= month_days(month_q, leap) && dow_q < 3'd7);
  p_month_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    month_q >= 4'd1 && month_q <= 4'd12);
  p_new_year_r4: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && !load && last_day && month_q == 4'd12
    |=> month_q == 4'd1 && date_q == 5'd1 && year_q == $past(year_q) + YEAR_ONE);
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int SW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [SW_W-1:0] arm_value,
  input  logic            min_roll,
  output logic [SW_W-1:0] left_q,
  output logic            expired
);
  localparam logic [SW_W-1:0] SW_ONE = {{(SW_W-1){1'b0}}, 1'b1};

  assign expired = min_roll & ~arm & (left_q == SW_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        left_q <= '0;
    else if (arm)                      left_q <= arm_value;
    else if (min_roll && left_q != '0) left_q <= left_q - SW_ONE;
  end

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    left_q == '0 && !arm |=> left_q == '0);
  p_expiry_reaches_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> left_q == '0);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int YEAR_W = 12,
  parameter int SW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [4:0]        load_hour,
  input  logic [5:0]        load_min,
  input  logic [5:0]        load_sec,
  input  logic [2:0]        load_dow,
  input  logic [4:0]        load_date,
  input  logic [3:0]        load_month,
  input  logic [YEAR_W-1:0] load_year,
  input  logic              alarm_en,
  input  logic [4:0]        alarm_hour,
  input  logic [5:0]        alarm_min,
  input  logic [5:0]        alarm_sec,
  input  logic              sw_load,
  input  logic [SW_W-1:0]   sw_value,
  input  logic [4:0]        irq_en,
  input  logic [4:0]        irq_clr,
  output logic [4:0]        hour,
  output logic [5:0]        min,
  output logic [5:0]        sec,
  output logic [2:0]        dow,
  output logic [4:0]        date,
  output logic [3:0]        month,
  output logic [YEAR_W-1:0] year,
  output logic [SW_W-1:0]   sw_left,
  output logic [4:0]        irq_flags,
  output logic              irq
);
  logic tick, min_roll, day_roll, alarm_hit, sw_done;
  logic [4:0] nxt_hour;
  logic [5:0] nxt_min, nxt_sec;
  logic [FLAG_N-1:0] events, flags_q;

  rtc_prescaler #(.STAGES(STAGES)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick));

  rtc_tod u_tod (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .ld_hour(load_hour), .ld_min(load_min), .ld_sec(load_sec),
    .hour_q(hour), .min_q(min), .sec_q(sec),
    .nxt_hour(nxt_hour), .nxt_min(nxt_min), .nxt_sec(nxt_sec),
    .min_roll(min_roll), .day_roll(day_roll));

  rtc_date #(.YEAR_W(YEAR_W)) u_date (
    .clk(clk), .rst_n(rst_n), .day_roll(day_roll), .load(load),
    .ld_dow(load_dow), .ld_date(load_date), .ld_month(load_month), .ld_year(load_year),
    .dow_q(dow), .date_q(date), .month_q(month), .year_q(year));

  rtc_stopwatch #(.SW_W(SW_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .arm(sw_load), .arm_value(sw_value),
    .min_roll(min_roll), .left_q(sw_left), .expired(sw_done));

  assign alarm_hit = tick & alarm_en & (nxt_hour == alarm_hour) &
                     (nxt_min == alarm_min) & (nxt_sec == alarm_sec);

  always_comb begin
    events             = '0;
    events[FLAG_SEC]   = tick;
    events[FLAG_MIN]   = min_roll;
    events[FLAG_MIDNT] = day_roll;
    events[FLAG_ALARM] = alarm_hit;
    events[FLAG_SW]    = sw_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~irq_clr) | (events & irq_en);
  end

  assign irq_flags = flags_q;
  assign irq       = |flags_q;

  p_midnight_in_minute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |-> min_roll && tick);
  p_alarm_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> hour == $past(alarm_hour) && min == $past(alarm_min) && sec == $past(alarm_sec));
  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~irq_clr)) |=> ((flags_q & $past(flags_q & ~irq_clr)) == $past(flags_q & ~irq_clr)));

  for (genvar k = 0; k < FLAG_N; k++) begin : g_flag_chk
    p_masked_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_q[k] && !irq_en[k] |=> !flags_q[k]);
  end
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int STG = 2;
  localparam int PER = 1 << STG;
  localparam int YW  = 12;
  localparam int SWW = 8;

  logic clk = 0, rst_n = 0;
  logic load = 0, alarm_en = 0, sw_load = 0;
  logic [4:0] load_hour = 0, alarm_hour = 0;
  logic [5:0] load_min = 0, load_sec = 0, alarm_min = 0, alarm_sec = 0;
  logic [2:0] load_dow = 0;
  logic [4:0] load_date = 1;
  logic [3:0] load_month = 1;
  logic [YW-1:0] load_year = 0;
  logic [SWW-1:0] sw_value = 0;
  logic [4:0] irq_en = 0, irq_clr = 0;
  logic [4:0] hour, date, irq_flags;
  logic [5:0] min, sec;
  logic [2:0] dow;
  logic [3:0] month;
  logic [YW-1:0] year;
  logic [SWW-1:0] sw_left;
  logic irq;

  int nchk = 0, nerr = 0, cyc = 0;

  rtc_calendar #(.STAGES(STG), .YEAR_W(YW), .SW_W(SWW)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_hour(load_hour), .load_min(load_min),
    .load_sec(load_sec), .load_dow(load_dow), .load_date(load_date), .load_month(load_month),
    .load_year(load_year), .alarm_en(alarm_en), .alarm_hour(alarm_hour), .alarm_min(alarm_min),
    .alarm_sec(alarm_sec), .sw_load(sw_load), .sw_value(sw_value), .irq_en(irq_en),
    .irq_clr(irq_clr), .hour(hour), .min(min), .sec(sec), .dow(dow), .date(date),
    .month(month), .year(year), .sw_left(sw_left), .irq_flags(irq_flags), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input int h, input int m, input int s, input int dw,
                         input int dt, input int mo, input int yr);
    load_hour = 5'(h); load_min = 6'(m); load_sec = 6'(s);
    load_dow = 3'(dw); load_date = 5'(dt); load_month = 4'(mo); load_year = YW'(yr);
    load = 1;
    @(posedge clk); @(negedge clk);
    load = 0;
  endtask

  // clears flags on the first edge, then lands just after the next second update
  task automatic next_sec();
    irq_clr = 5'h1f;
    @(posedge clk); @(negedge clk);
    irq_clr = 0;
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_flags();
    irq_clr = 5'h1f;
    @(posedge clk); @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic arm_sw(input int v);
    sw_value = SWW'(v); sw_load = 1;
    @(posedge clk); @(negedge clk);
    sw_load = 0;
  endtask

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  initial begin
    int d, m, y, dw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 hour", hour, 0); chk("R11 min", min, 0); chk("R11 sec", sec, 0);
    chk("R11 dow", dow, 0); chk("R11 date", date, 1); chk("R11 month", month, 1);
    chk("R11 year", year, 0); chk("R11 sw", sw_left, 0); chk("R11 flags", irq_flags, 0);

    // R1 period after load
    do_load(5, 6, 7, 0, 1, 1, 2000);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    chk("R1 no early update", sec, 7);
    @(posedge clk); @(negedge clk);
    chk("R1 update after full period", sec, 8);

    // R2/R6 hour sweep
    irq_en = 5'b00011;
    do_load(0, 0, 0, 0, 1, 1, 2000);
    for (int t = 1; t <= 3600; t++) begin
      next_sec();
      chk("R2 sec", sec, t % 60);
      chk("R2 min", min, (t / 60) % 60);
      chk("R2 hour", hour, t / 3600);
      chk("R6 sec/min flags", irq_flags, (t % 60 == 0) ? 3 : 1);
    end
    do_load(12, 59, 59, 0, 1, 1, 2000);
    next_sec();
    chk("R2 hour carry", hour, 13);
    chk("R2 min wrap", min, 0);

    // R3/R4/R6 day sweep over four years
    irq_en = 5'h1f; alarm_en = 0;
    d = 1; m = 1; y = 2023; dw = 0;
    for (int i = 0; i < 1461; i++) begin
      do_load(23, 59, 59, dw, d, m, y);
      next_sec();
      dw = (dw + 1) % 7;
      if (d == mdays(m, y)) begin
        d = 1;
        if (m == 12) begin m = 1; y++; end else m++;
      end else d++;
      chk("R3 dow", dow, dw); chk("R3 date", date, d);
      chk("R4 month", month, m); chk("R4 year", year, y);
      chk("R2 midnight time", hour * 3600 + min * 60 + sec, 0);
      chk("R6 midnight flags", irq_flags, 7);
    end

    // R7 alarm
    irq_en = 5'b01000; alarm_en = 1;
    alarm_hour = 10; alarm_min = 20; alarm_sec = 30;
    clr_flags();
    do_load(10, 20, 28, 0, 1, 1, 2000);
    chk("R7 no flag at load", irq_flags, 0);
    next_sec();
    chk("R7 not yet", irq_flags, 0);
    next_sec();
    chk("R7 alarm fires", irq_flags, 8);
    chk("R10 irq high", irq, 1);
    clr_flags();
    do_load(10, 20, 30, 0, 1, 1, 2000);
    chk("R7 matching load ignored", irq_flags, 0);
    next_sec();
    chk("R7 past alarm", irq_flags, 0);
    alarm_en = 0;
    do_load(10, 20, 29, 0, 1, 1, 2000);
    next_sec();
    chk("R7 disabled alarm", irq_flags, 0);

    // R8 stopwatch
    irq_en = 5'b10000;
    arm_sw(2);
    chk("R8 armed", sw_left, 2);
    do_load(12, 0, 59, 0, 1, 1, 2000);
    next_sec();
    chk("R8 decrement", sw_left, 1); chk("R8 no flag yet", irq_flags, 0);
    do_load(12, 1, 59, 0, 1, 1, 2000);
    next_sec();
    chk("R8 reach zero", sw_left, 0); chk("R8 expiry flag", irq_flags, 16);
    do_load(12, 2, 59, 0, 1, 1, 2000);
    next_sec();
    chk("R8 stays zero", sw_left, 0); chk("R8 no repeat flag", irq_flags, 0);
    arm_sw(0);
    do_load(12, 3, 59, 0, 1, 1, 2000);
    next_sec();
    chk("R8 zero load no flag", irq_flags, 0);
    arm_sw(3);
    do_load(8, 30, 59, 0, 1, 1, 2000);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    sw_value = 5; sw_load = 1;
    @(posedge clk); @(negedge clk);
    sw_load = 0;
    chk("R8 arm beats decrement", sw_left, 5);
    chk("R2 minute still advanced", min, 31);

    // R5 load beats due update
    do_load(5, 6, 7, 0, 1, 1, 2000);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    do_load(5, 6, 40, 0, 1, 1, 2000);
    chk("R5 load wins", sec, 40);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 prescaler cleared", sec, 40);
    @(posedge clk); @(negedge clk);
    chk("R1 first second after load", sec, 41);

    // R9 set versus clear in the same cycle
    irq_en = 5'b00001;
    clr_flags();
    do_load(1, 1, 1, 0, 1, 1, 2000);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    irq_clr = 5'h1f;
    @(posedge clk); @(negedge clk);
    irq_clr = 0;
    chk("R9 set wins over clear", irq_flags, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 sticky", irq_flags, 1);
    clr_flags();
    chk("R9 cleared", irq_flags, 0);
    chk("R10 irq low", irq, 0);

    // R10 all disabled across midnight
    irq_en = 0;
    do_load(23, 59, 59, 0, 31, 12, 2000);
    next_sec();
    chk("R10 masked flags", irq_flags, 0); chk("R10 masked irq", irq, 0);

    // coincident midnight, alarm, minute and second on 28 Feb of a non-leap year
    irq_en = 5'h1f; alarm_en = 1;
    alarm_hour = 0; alarm_min = 0; alarm_sec = 0;
    do_load(23, 59, 59, 3, 28, 2, 2023);
    next_sec();
    chk("R6 R7 joint flags", irq_flags, 15);
    chk("R3 date after 28 Feb", date, 1); chk("R4 month March", month, 3);
    chk("R3 dow step", dow, 4);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule